// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests for a single processor and presents the most urgent one as an interrupt line plus a readable vector. Requests arrive on a group of external lines and a group of internal lines. Each external line can be set to edge or level detection with a chosen polarity. Internal lines are always level sensitive and active high. Every source owns a configuration word that holds a mask, a priority from 0 to 15 and an 8-bit vector.

Software reaches the controller through a word-wide register port with a one-cycle read latency. An interrupt handler reads the acknowledge location to get the winning vector. That read moves the source into service. The handler then writes the end-of-interrupt location to retire the source.

Sources already in service block any request at their own priority or below, so handlers can nest. A current-task threshold holds back every source whose priority does not exceed it. A source's priority, vector, polarity and sense are locked for as long as the source is requesting or in service. Its mask can still be changed at any time.

Top module: `vpic_top`

## Requirements
- R1: After reset, every source word reads 0x8000_0000 (masked, all other fields 0), the threshold reads 15, the spurious vector reads 0xFF and `irq_o` is low.
- R2: Source i is at word address i. Its word holds mask at bit 31, the read-only activity flag at bit 30, polarity at bit 23, sense at bit 22, priority at bits 19:16 and vector at bits 7:0. All other bits read 0. The threshold is at address 0x20 (bits 3:0), acknowledge at 0x21, end-of-interrupt at 0x22 and the spurious vector at 0x23 (bits 7:0).
- R3: Internal sources (indices N_EXT and above) read polarity and sense as 0 whatever is written. They request while their line is high.
- R4: An external source with sense 0 latches a request on a rising edge (polarity 1) or on a falling edge (polarity 0). The latched request clears when the source is acknowledged.
- R5: An external source with sense 1 requests for as long as its line equals its polarity bit.
- R6: The activity flag is 1 while the source is requesting or in service. While it is 1, writes leave polarity, sense, priority and vector unchanged, but the mask bit still takes the written value.
- R7: A source can be delivered only if its mask is 0 and its priority is strictly greater than the threshold. `irq_o` is high when some source can be delivered.
- R8: Among deliverable sources the highest priority wins, and on equal priority the lower index wins. A source in service blocks every source whose priority is equal to or lower than its own.
- R9: A read of the acknowledge address returns the winner's vector and puts the winner in service. With no winner it returns the spurious vector and changes no source state.
- R10: Any write to the end-of-interrupt address retires the in-service source with the highest priority, which is the one most recently acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_lines_i | input | N_EXT | External request lines |
| int_lines_i | input | N_INT | Internal request lines, active high |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after the read strobe |
| rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The bench builds the controller with four external and two internal sources. This is enough to exercise both source kinds, both edge polarities, level detection, an equal-priority tie and a nested acknowledge, all within a short run. Reads are scored against expected words queued by the driver. The scored reads cover the activity flag during pending and in-service states, spurious acknowledges with and without a masked request, and the retire order of two nested handlers.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int DATA_W  = 32;
  localparam int PRI_W   = 4;
  localparam int VEC_W   = 8;
  localparam int NUM_PRI = 1 << PRI_W;

  localparam int BIT_MASK  = 31;
  localparam int BIT_ACT   = 30;
  localparam int BIT_POL   = 23;
  localparam int BIT_SENSE = 22;
  localparam int PRI_LSB   = 16;

  localparam int OFS_THRESH = 32;
  localparam int OFS_ACK    = 33;
  localparam int OFS_EOI    = 34;
  localparam int OFS_SPUR   = 35;

  typedef struct packed {
    logic             mask;
    logic             pol;
    logic             sense;
    logic [PRI_W-1:0] prio;
    logic [VEC_W-1:0] vec;
  } src_cfg_t;
endpackage

// File: rtl/vpic_source.sv
module vpic_source
  import vpic_pkg::*;
#(
  parameter bit INTERNAL = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_i,
  input  logic              cfg_we_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              take_i,
  input  logic              retire_i,
  output src_cfg_t          cfg_o,
  output logic              req_o,
  output logic              insvc_o,
  output logic              active_o
);
  src_cfg_t cfg;
  logic line_q, line_p, edge_pend, insvc, edge_now, level_hit;

  assign edge_now  = cfg.pol ? (line_q & ~line_p) : (~line_q & line_p);
  assign level_hit = (line_q == cfg.pol);

  generate
    if (INTERNAL) begin : g_int
      assign req_o = line_q;
    end else begin : g_ext
      assign req_o = cfg.sense ? level_hit : edge_pend;
    end
  endgenerate

  assign active_o = req_o | insvc;
  assign insvc_o  = insvc;
  assign cfg_o    = cfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q    <= 1'b0;
      line_p    <= 1'b0;
      edge_pend <= 1'b0;
      insvc     <= 1'b0;
      cfg       <= '{mask: 1'b1, default: '0};
    end else begin
      line_q <= line_i;
      line_p <= line_q;
      if (!INTERNAL && !cfg.sense && edge_now) edge_pend <= 1'b1;
      else if (take_i || cfg.sense)            edge_pend <= 1'b0;
      if (take_i)        insvc <= 1'b1;
      else if (retire_i) insvc <= 1'b0;
      if (cfg_we_i) begin
        cfg.mask <= cfg_wdata_i[BIT_MASK];
        if (!active_o) begin
          cfg.pol   <= INTERNAL ? 1'b0 : cfg_wdata_i[BIT_POL];
          cfg.sense <= INTERNAL ? 1'b0 : cfg_wdata_i[BIT_SENSE];
          cfg.prio  <= cfg_wdata_i[PRI_LSB +: PRI_W];
          cfg.vec   <= cfg_wdata_i[VEC_W-1:0];
        end
      end
    end
  end

  // R6
  cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we_i && active_o) |=> ($stable(cfg.prio) && $stable(cfg.vec) &&
                                $stable(cfg.pol) && $stable(cfg.sense)));

  // R4
  edge_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (take_i && !edge_now) |=> !edge_pend);
endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter
  import vpic_pkg::*;
#(
  parameter int NSRC = 12,
  parameter int IDW  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSRC-1:0]       cand_i,
  input  logic [NSRC*PRI_W-1:0] prio_flat_i,
  input  logic [PRI_W-1:0]      thr_i,
  output logic                  found_o,
  output logic [IDW-1:0]        win_id_o,
  output logic [PRI_W-1:0]      win_prio_o
);
  always_comb begin
    found_o    = 1'b0;
    win_id_o   = '0;
    win_prio_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand_i[i] && (prio_flat_i[i*PRI_W +: PRI_W] > thr_i) &&
          (!found_o || (prio_flat_i[i*PRI_W +: PRI_W] > win_prio_o))) begin
        found_o    = 1'b1;
        win_id_o   = IDW'(i);
        win_prio_o = prio_flat_i[i*PRI_W +: PRI_W];
      end
    end
  end

  // R7
  win_above_thr_chk: assert property (@(posedge clk) disable iff (rst)
    found_o |-> (win_prio_o > thr_i));
endmodule

// File: rtl/vpic_isr_stack.sv
module vpic_isr_stack
  import vpic_pkg::*;
#(
  parameter int IDW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [PRI_W-1:0] push_prio_i,
  input  logic [IDW-1:0]   push_id_i,
  input  logic             pop_i,
  output logic             top_valid_o,
  output logic [PRI_W-1:0] top_prio_o,
  output logic [IDW-1:0]   top_id_o
);
  logic [NUM_PRI-1:0] isr_q;
  logic [IDW-1:0]     ids_q [NUM_PRI];

  always_comb begin
    top_valid_o = |isr_q;
    top_prio_o  = '0;
    for (int p = 0; p < NUM_PRI; p++)
      if (isr_q[p]) top_prio_o = PRI_W'(p);
    top_id_o = ids_q[top_prio_o];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q <= '0;
    end else begin
      if (pop_i && top_valid_o) isr_q[top_prio_o] <= 1'b0;
      if (push_i)               isr_q[push_prio_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) ids_q[push_prio_i] <= push_id_i;
  end

  // R8
  nest_order_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && top_valid_o) |-> (push_prio_i > top_prio_o));

  // R10
  pop_top_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_i && top_valid_o && !push_i) |=> !isr_q[$past(top_prio_o)]);
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int N_EXT  = 8,
  parameter int N_INT  = 4,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EXT-1:0]  ext_lines_i,
  input  logic [N_INT-1:0]  int_lines_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              irq_o
);
  localparam int NSRC = N_EXT + N_INT;
  localparam int IDW  = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [ADDR_W-1:0] A_THR  = ADDR_W'(OFS_THRESH);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFS_ACK);
  localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(OFS_EOI);
  localparam logic [ADDR_W-1:0] A_SPUR = ADDR_W'(OFS_SPUR);

  src_cfg_t              cfg_a [NSRC];
  logic [DATA_W-1:0]     word_a [NSRC];
  logic [NSRC-1:0]       req, insvc, active, cand, take, retire;
  logic [NSRC*PRI_W-1:0] prio_flat;
  logic [PRI_W-1:0]      thr_q, thr_eff, win_prio, top_prio;
  logic [VEC_W-1:0]      spur_q;
  logic [IDW-1:0]        win_id, top_id;
  logic                  found, top_valid, ack_fire, eoi_fire;

  assign ack_fire = rd_en_i && (addr_i == A_ACK);
  assign eoi_fire = wr_en_i && (addr_i == A_EOI);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic line;
    if (i < N_EXT) begin : g_e
      assign line = ext_lines_i[i];
    end else begin : g_i
      assign line = int_lines_i[i-N_EXT];
    end
    assign take[i]   = ack_fire && found && (win_id == IDW'(i));
    assign retire[i] = eoi_fire && top_valid && (top_id == IDW'(i));
    vpic_source #(.INTERNAL(i >= N_EXT)) u_src (
      .clk(clk), .rst(rst), .line_i(line),
      .cfg_we_i(wr_en_i && (addr_i == ADDR_W'(i))), .cfg_wdata_i(wdata_i),
      .take_i(take[i]), .retire_i(retire[i]), .cfg_o(cfg_a[i]),
      .req_o(req[i]), .insvc_o(insvc[i]), .active_o(active[i]));
    assign cand[i] = !cfg_a[i].mask && req[i] && !insvc[i];
    assign prio_flat[i*PRI_W +: PRI_W] = cfg_a[i].prio;
    assign word_a[i] = {cfg_a[i].mask, active[i], 6'b0, cfg_a[i].pol,
                        cfg_a[i].sense, 2'b0, cfg_a[i].prio, 8'b0, cfg_a[i].vec};
  end

  assign thr_eff = (top_valid && (top_prio > thr_q)) ? top_prio : thr_q;

  vpic_arbiter #(.NSRC(NSRC), .IDW(IDW)) u_arb (
    .clk(clk), .rst(rst), .cand_i(cand), .prio_flat_i(prio_flat),
    .thr_i(thr_eff), .found_o(found), .win_id_o(win_id), .win_prio_o(win_prio));

  vpic_isr_stack #(.IDW(IDW)) u_isr (
    .clk(clk), .rst(rst), .push_i(ack_fire && found), .push_prio_i(win_prio),
    .push_id_i(win_id), .pop_i(eoi_fire), .top_valid_o(top_valid),
    .top_prio_o(top_prio), .top_id_o(top_id));

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q    <= '1;
      spur_q   <= '1;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      irq_o    <= found;
      rvalid_o <= rd_en_i;
      if (wr_en_i && addr_i == A_THR)  thr_q  <= wdata_i[PRI_W-1:0];
      if (wr_en_i && addr_i == A_SPUR) spur_q <= wdata_i[VEC_W-1:0];
      if (rd_en_i) begin
        rdata_o <= '0;
        if (addr_i == A_THR)  rdata_o <= DATA_W'(thr_q);
        if (addr_i == A_SPUR) rdata_o <= DATA_W'(spur_q);
        if (ack_fire) rdata_o <= found ? DATA_W'(cfg_a[win_id].vec) : DATA_W'(spur_q);
        for (int i = 0; i < NSRC; i++)
          if (addr_i == ADDR_W'(i)) rdata_o <= word_a[i];
      end
    end
  end

  // R9
  spur_vec_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_fire && !found) |=> (rdata_o == DATA_W'($past(spur_q))));

  // R9
  spur_nochange_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_fire && !found && !eoi_fire) |=> $stable(insvc));
endmodule

// File: tb/vpic_top_bench.sv
module vpic_top_bench;
  localparam int NE = 4;
  localparam int NI = 2;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NE-1:0] ext = '0;
  logic [NI-1:0] intl = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rvalid, irq;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  vpic_top #(.N_EXT(NE), .N_INT(NI), .ADDR_W(AW)) u_vpic_top (
    .clk(clk), .rst(rst), .ext_lines_i(ext), .int_lines_i(intl),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid), .irq_o(irq));

  // scoreboard monitor
  always @(negedge clk) begin
    if (rvalid) begin
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL unexpected read data %h", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          mismatched++;
          $display("FAIL %s: got %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    settle();
    compared++;
    if (irq !== e) begin
      mismatched++;
      $display("FAIL %s: irq got %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(0, 32'h8000_0000, "R1 ext word");
    rd(4, 32'h8000_0000, "R1 int word");
    rd(32, 32'h0000_000F, "R1 threshold");
    rd(35, 32'h0000_00FF, "R1 spurious");
    chk_irq(1'b0, "R1 irq");
    // R2 layout, R5 level config
    wr(0, 32'h7FC5_FFA1);
    rd(0, 32'h00C5_00A1, "R2 field layout");
    // R3 internal ignores pol/sense
    wr(4, 32'h00C3_0042);
    rd(4, 32'h0003_0042, "R3 internal pol/sense zero");
    // R7 threshold blocks, R6 activity lock
    intl[0] = 1'b1;
    chk_irq(1'b0, "R7 below threshold 15");
    rd(4, 32'h4003_0042, "R6 activity set");
    wr(4, 32'h0009_0055);
    rd(4, 32'h4003_0042, "R6 locked write ignored");
    wr(4, 32'h8009_0055);
    rd(4, 32'hC003_0042, "R6 mask still writable");
    wr(4, 32'h0003_0042);
    wr(32, 3);
    chk_irq(1'b0, "R7 equal to threshold");
    wr(32, 2);
    chk_irq(1'b1, "R7 above threshold");
    // R9 acknowledge, R10 retire
    rd(33, 32'h0000_0042, "R9 ack vector");
    chk_irq(1'b0, "R8 self blocked in service");
    intl[0] = 1'b0;
    settle();
    rd(4, 32'h4003_0042, "R9 in service active");
    wr(34, 0);
    rd(4, 32'h0003_0042, "R10 retired");
    // R4 rising edge
    wr(1, 32'h0086_0011);
    ext[1] = 1'b1; settle(); ext[1] = 1'b0;
    chk_irq(1'b1, "R4 rising edge latched");
    rd(33, 32'h0000_0011, "R4 ack rising");
    rd(1, 32'h4086_0011, "R4 in service");
    wr(34, 0);
    rd(1, 32'h0086_0011, "R4 cleared after ack");
    // R4 falling edge
    wr(2, 32'h0007_0022);
    ext[2] = 1'b1; settle();
    rd(2, 32'h0007_0022, "R4 rise ignored when falling");
    ext[2] = 1'b0; settle();
    rd(2, 32'h4007_0022, "R4 falling latched");
    rd(33, 32'h0000_0022, "R4 ack falling");
    wr(34, 0);
    rd(2, 32'h0007_0022, "R4 falling retired");
    // R8 tie and nesting
    wr(3, 32'h00C5_0033);
    wr(5, 32'h0008_0058);
    ext[0] = 1'b1; ext[3] = 1'b1;
    chk_irq(1'b1, "R5 level pending");
    rd(33, 32'h0000_00A1, "R8 tie lower index");
    chk_irq(1'b0, "R8 equal priority blocked");
    intl[1] = 1'b1;
    chk_irq(1'b1, "R8 higher nests");
    rd(33, 32'h0000_0058, "R8 nested ack");
    intl[1] = 1'b0;
    wr(34, 0);
    rd(5, 32'h0008_0058, "R10 most recent retired");
    ext[0] = 1'b0; settle();
    rd(0, 32'h40C5_00A1, "R10 outer still in service");
    wr(34, 0);
    chk_irq(1'b1, "R8 waiting source released");
    rd(33, 32'h0000_0033, "R8 ack second of tie");
    ext[3] = 1'b0;
    wr(34, 0);
    rd(3, 32'h00C5_0033, "R5 level dropped");
    // R9 spurious
    wr(35, 32'h0000_007E);
    rd(35, 32'h0000_007E, "R2 spurious register");
    rd(33, 32'h0000_007E, "R9 spurious empty");
    wr(0, 32'h80C5_00A1);
    ext[0] = 1'b1;
    chk_irq(1'b0, "R7 masked");
    rd(33, 32'h0000_007E, "R9 spurious masked");
    rd(0, 32'hC0C5_00A1, "R9 no state change");
    wr(0, 32'h00C5_00A1);
    chk_irq(1'b1, "R7 unmasked");
    rd(33, 32'h0000_00A1, "R9 ack after unmask");
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL scoreboard: %0d reads not returned, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule